// File: doc/BRIEF.md
# Quadrature Oscillator Mixer for Digital Downconversion

This block sits between an ADC and the first decimating filter of a receiver. It takes a stream of real, signed intermediate-frequency samples, each marked by a valid strobe. It multiplies every sample by a cosine and by a negated sine, so that the chosen channel moves to complex baseband as an in-phase (I) and quadrature (Q) pair. The two carriers come from a numerically controlled oscillator. That oscillator is a 32-bit phase accumulator, which advances once per accepted sample by a programmable tuning word. The output frequency is therefore the tuning word times the sample rate divided by 2^32.

The oscillator waveform comes from a lookup table that holds only one quarter of a sine cycle, 256 points. Mirroring the table index and flipping the sign rebuild all four quadrants. Every multiply takes two 16-bit signed operands, so each product fits a single 18x18 multiply slice. The products are rounded to 18 bits and registered. They reach the output three clocks after the sample strobe, with a shared valid strobe. A phase-clear input restarts the oscillator at phase zero. Changing the tuning word never disturbs the running phase.

Top module: `ddc_nco_mixer`

## Requirements
- R1: The phase accumulator is 32 bits wide. Each valid sample is mixed with the accumulator value present before that sample, and the accumulator then adds the tuneWord present in the same cycle. When sampleValid is low, the phase holds and tuneWord is ignored.
- R2: Phase bits [31:22] address the carrier. Bits [31:30] are the quadrant q and bits [29:22] are the fine index a. The table entry is T(k) = round(32767*sin(2*pi*(k+0.5)/1024)) for k = 0..255. The sine is T(a), T(255-a), -T(a), -T(255-a) for q = 0, 1, 2, 3. The cosine is T(255-a), -T(a), -T(255-a), T(a) for q = 0, 1, 2, 3.
- R3: iOut equals floor((x*cos + 8192) / 16384) as an 18-bit signed value, where x is the 16-bit signed sample.
- R4: qOut equals floor((-(x*sin) + 8192) / 16384) as an 18-bit signed value.
- R5: outValid goes high exactly 3 clock cycles after each sampleValid, once per sample. Back-to-back samples give back-to-back outputs.
- R6: iOut and qOut hold their last values in every cycle where outValid is low.
- R7: A new tuneWord first changes the phase step for the sample after the one it arrives with. The phase is not reset, so the phase stays continuous across the change.
- R8: phaseClr high in a cycle sets the accumulator to zero. The next valid sample after that cycle is mixed at phase 0. A sample that arrives in the same cycle as phaseClr still uses the old phase.
- R9: While rstN is low, the accumulator, iOut, qOut and outValid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | Strobe marking a valid input sample |
| sampleIn | input | 16 | Signed IF sample |
| tuneWord | input | 32 | Frequency tuning word (phase step per sample) |
| phaseClr | input | 1 | Clears the oscillator phase to zero |
| iOut | output | 18 | Rounded in-phase product |
| qOut | output | 18 | Rounded quadrature product |
| outValid | output | 1 | Strobe marking valid iOut/qOut |

## Verification
A tuning word of 2^22 steps through every one of the 1024 phase points, once with full-scale positive samples and once with full-scale negative samples. These sweeps expose a wrong mirror index or a wrong quadrant sign, which would show up as a sign flip or an off-by-one table point in one quadrant. They also expose a wrong rounding or truncation at the extremes, which would give a one-count error.

A long run with gaps in the strobe and junk on the tuning word during the idle cycles catches an accumulator that advances without a valid sample, and outputs that change while outValid is low. Mid-stream tuning changes catch a design that applies the new step one sample early or resets the phase. Phase clears, issued alone and alongside a sample, catch a clear with the wrong priority against that sample.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  // Stage load strobes handed from control to datapath
  typedef struct packed {
    logic ld1;  // capture sample and carrier values
    logic ld2;  // capture raw products
    logic ld3;  // capture rounded outputs
  } mixStrobe_t;

  localparam real PI_R = 3.14159265358979323846;

  // Quarter-wave point k, sampled at the centre of its bin
  function automatic int quarterSine(int k, int fineW, int tabW);
    real ang;
    real amp;
    ang = 2.0 * PI_R * (real'(k) + 0.5) / real'(4 << fineW);
    amp = real'((1 << (tabW - 1)) - 1);
    return $rtoi($floor(amp * $sin(ang) + 0.5));
  endfunction

endpackage

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [PHASE_W-1:0] tuneWord,
  input  logic              phaseClr,
  output logic [ADDR_W-1:0] tabAddr,
  output mixStrobe_t        strb,
  output logic              outValid
);

  logic [PHASE_W-1:0] phaseAcc;
  logic v1, v2, v3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            phaseAcc <= '0;
    else if (phaseClr)    phaseAcc <= '0;
    else if (sampleValid) phaseAcc <= phaseAcc + tuneWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= sampleValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  assign tabAddr  = phaseAcc[PHASE_W-1 -: ADDR_W];
  assign strb.ld1 = sampleValid;
  assign strb.ld2 = v1;
  assign strb.ld3 = v2;
  assign outValid = v3;

  // R1
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleValid && !phaseClr) |=> $stable(phaseAcc));

  // R8
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseClr |=> (phaseAcc == '0));

endmodule

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 16,
  parameter int TAB_W  = 16,
  parameter int OUT_W  = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mixStrobe_t               strb,
  input  logic [ADDR_W-1:0]        tabAddr,
  input  logic signed [SAMP_W-1:0] sampleIn,
  output logic signed [OUT_W-1:0]  iOut,
  output logic signed [OUT_W-1:0]  qOut
);

  localparam int FINE_W = ADDR_W - 2;
  localparam int TAB_N  = 1 << FINE_W;
  localparam int PROD_W = SAMP_W + TAB_W;
  localparam int SHIFT  = PROD_W - OUT_W;
  localparam logic signed [PROD_W+1:0] RND = (PROD_W+2)'(1) <<< (SHIFT - 1);
  localparam logic signed [TAB_W-1:0] MIN_TAB = {1'b1, {(TAB_W-1){1'b0}}};

  // Quarter-wave table, built from a constant function
  logic signed [TAB_W-1:0] quarterTab [TAB_N];
  for (genvar k = 0; k < TAB_N; k++) begin : g_tab
    localparam int ENT = quarterSine(k, FINE_W, TAB_W);
    assign quarterTab[k] = TAB_W'(ENT);
  end

  // Quadrant reconstruction
  logic [1:0]              quad;
  logic [FINE_W-1:0]       fineIdx, mirIdx;
  logic signed [TAB_W-1:0] sinMag, cosMag, sinVal, cosVal;

  always_comb begin
    quad    = tabAddr[ADDR_W-1 -: 2];
    fineIdx = tabAddr[FINE_W-1:0];
    mirIdx  = ~fineIdx;
    sinMag  = quad[0] ? quarterTab[mirIdx] : quarterTab[fineIdx];
    cosMag  = quad[0] ? quarterTab[fineIdx] : quarterTab[mirIdx];
    sinVal  = quad[1] ? -sinMag : sinMag;
    cosVal  = (quad[1] ^ quad[0]) ? -cosMag : cosMag;
  end

  // Stage 1: operands
  logic signed [SAMP_W-1:0] sampR;
  logic signed [TAB_W-1:0]  cosR, sinR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampR <= '0;
      cosR  <= '0;
      sinR  <= '0;
    end else if (strb.ld1) begin
      sampR <= sampleIn;
      cosR  <= cosVal;
      sinR  <= sinVal;
    end
  end

  // Stage 2: products (16x16 signed each)
  logic signed [PROD_W-1:0] mulI, mulQ;
  logic signed [PROD_W:0]   negQ;
  logic signed [PROD_W-1:0] prodI;
  logic signed [PROD_W:0]   prodQ;

  assign mulI = sampR * cosR;
  assign mulQ = sampR * sinR;
  assign negQ = -$signed({mulQ[PROD_W-1], mulQ});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodI <= '0;
      prodQ <= '0;
    end else if (strb.ld2) begin
      prodI <= mulI;
      prodQ <= negQ;
    end
  end

  // Stage 3: round half up and keep OUT_W bits
  logic signed [PROD_W+1:0] sumI, sumQ;

  assign sumI = $signed({{2{prodI[PROD_W-1]}}, prodI}) + RND;
  assign sumQ = $signed({prodQ[PROD_W], prodQ}) + RND;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iOut <= '0;
      qOut <= '0;
    end else if (strb.ld3) begin
      iOut <= sumI[SHIFT +: OUT_W];
      qOut <= sumQ[SHIFT +: OUT_W];
    end
  end

  // R2
  carrier_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ld2 |-> (cosR != MIN_TAB && sinR != MIN_TAB));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ld3 |=> ($stable(iOut) && $stable(qOut)));

endmodule

// File: rtl/ddc_nco_mixer.sv
module ddc_nco_mixer
  import ddc_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 16,
  parameter int TAB_W   = 16,
  parameter int OUT_W   = 18
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [SAMP_W-1:0] sampleIn,
  input  logic [PHASE_W-1:0]       tuneWord,
  input  logic                     phaseClr,
  output logic signed [OUT_W-1:0]  iOut,
  output logic signed [OUT_W-1:0]  qOut,
  output logic                     outValid
);

  mixStrobe_t        strb;
  logic [ADDR_W-1:0] tabAddr;

  ddc_ctrl #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .tuneWord(tuneWord),
    .phaseClr(phaseClr), .tabAddr(tabAddr), .strb(strb), .outValid(outValid)
  );

  ddc_datapath #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .TAB_W(TAB_W), .OUT_W(OUT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .tabAddr(tabAddr),
    .sampleIn(sampleIn), .iOut(iOut), .qOut(qOut)
  );

  // R5
  latency_fwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> ##3 outValid);

  // R5
  latency_bwd_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleValid, 3));

endmodule

// File: tb/ddc_nco_mixer_tb.sv
module ddc_nco_mixer_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic [31:0] tuneWord = '0;
  logic phaseClr = 1'b0;
  logic signed [17:0] iOut, qOut;
  logic outValid;

  always #4 clk = ~clk;  // 125 MHz

  ddc_nco_mixer dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .tuneWord(tuneWord), .phaseClr(phaseClr), .iOut(iOut), .qOut(qOut),
    .outValid(outValid)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;
  logic [31:0] phaseM = '0;
  logic [31:0] seed = 32'h1357_9bdf;

  typedef struct {
    longint ei;
    longint eq;
    int     cyc;
    string  tag;
  } exp_t;
  exp_t expQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // R2 reference table, from its formula
  function automatic longint tabT(int k);
    real ang;
    ang = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / 1024.0;
    return longint'($rtoi($floor(32767.0 * $sin(ang) + 0.5)));
  endfunction

  function automatic longint refSin(int p);
    int q = (p >> 8) & 3;
    int a = p & 255;
    case (q)
      0: return tabT(a);
      1: return tabT(255 - a);
      2: return -tabT(a);
      default: return -tabT(255 - a);
    endcase
  endfunction

  function automatic longint refCos(int p);
    int q = (p >> 8) & 3;
    int a = p & 255;
    case (q)
      0: return tabT(255 - a);
      1: return -tabT(a);
      2: return -tabT(255 - a);
      default: return tabT(a);
    endcase
  endfunction

  task automatic sendSample(longint x, logic [31:0] tw, bit clr, string tag);
    exp_t e;
    int p;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleIn = 16'(x);
    tuneWord = tw;
    phaseClr = clr;
    p = int'(phaseM[31:22]);
    e.ei = (x * refCos(p) + 8192) >>> 14;   // R3
    e.eq = (-(x * refSin(p)) + 8192) >>> 14; // R4
    e.cyc = cyc + 3;                         // R5
    e.tag = tag;
    expQ.push_back(e);
    phaseM = clr ? 32'h0 : phaseM + tw;
  endtask

  task automatic idle(logic [31:0] junk, bit clr);
    @(negedge clk);
    sampleValid = 1'b0;
    sampleIn = 16'(junk[15:0]);
    tuneWord = junk;
    phaseClr = clr;
    if (clr) phaseM = '0;
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // Monitor
  logic signed [17:0] lastI = '0, lastQ = '0;
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          chk("R5 unexpected outValid", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk({e.tag, " R5 latency"}, cyc, e.cyc);
          chk({e.tag, " R3 iOut"}, longint'(iOut), e.ei);
          chk({e.tag, " R4 qOut"}, longint'(qOut), e.eq);
        end
        lastI = iOut;
        lastQ = qOut;
      end else begin
        chk("R6 iOut hold", longint'(iOut), longint'(lastI));
        chk("R6 qOut hold", longint'(qOut), longint'(lastQ));
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 iOut in reset", longint'(iOut), 0);
    chk("R9 qOut in reset", longint'(qOut), 0);
    chk("R9 outValid in reset", longint'(outValid), 0);
    rstN = 1'b1;

    // R2 full sweep with positive full scale
    for (int n = 0; n < 1024; n++) sendSample(32767, 32'h0040_0000, 0, "R2 sweep+");
    // R2 full sweep with negative full scale
    for (int n = 0; n < 1024; n++) sendSample(-32768, 32'h0040_0000, 0, "R2 sweep-");

    // R1/R6 gaps with junk tuning word while idle
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r = nextRand();
      sendSample(longint'($signed(r[31:16])), 32'h1234_5679, 0, "R1 gapped");
      if (r[3:2] == 2'b00) idle(nextRand(), 0);
      if (r[5:3] == 3'b111) begin idle(nextRand(), 0); idle(nextRand(), 0); end
    end

    // R7 tuning word changes mid-stream
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = nextRand();
      logic [31:0] tw;
      tw = ((n / 37) % 2 == 0) ? 32'h0A3D_70A4 : 32'hF123_4567 + 32'(n / 37);
      sendSample(longint'($signed(r[31:16])), tw, 0, "R7 retune");
    end

    // R8 clear alone, then clear together with a sample
    for (int n = 0; n < 20; n++) sendSample(20000 - n * 7, 32'h0777_1111, 0, "R8 pre");
    idle(32'hDEAD_BEEF, 1);
    for (int n = 0; n < 10; n++) sendSample(-12345 + n, 32'h0333_0000, 0, "R8 after clr");
    sendSample(31000, 32'h0555_0000, 1, "R8 clr with sample");
    for (int n = 0; n < 10; n++) sendSample(17 * n - 900, 32'h0220_0000, 0, "R8 after clr2");

    idle(32'h0, 0);
    repeat (6) idle(nextRand(), 0);
    chk("R5 all outputs seen", longint'(expQ.size()), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule